// File: doc/BRIEF.md
# Drift-Free Tenth-Second Time Accumulator

This block keeps a running elapsed-time value in unsigned fixed point, with 8 bits below the binary point, so one second is 256 LSBs. Each pulse on the tick strobe stands for one tenth of a second. A tenth of a second has no exact binary form. The block therefore adds the truncated quotient of 256/10 (25 LSBs) on every tick. It also adds the remainder (6) to a small error accumulator. When that accumulator reaches the divisor, the divisor is taken back out of it and the time gets one extra LSB on the same tick.

The time value is then always the floor of the exact elapsed time in LSBs. The error term tells how far the time sits below the exact value, in tenths of an LSB. Rounding error therefore never piles up, no matter how many ticks pass. A one-cycle flag marks each tick on which the extra LSB was added. The tick period, the fractional width and the time width are parameters.

Top module: `tenth_time_accum`

## Requirements
- R1: A synchronous active-high reset clears the time, the error accumulator and the correction flag to zero on the next clock edge, even when a tick is present in the same cycle.
- R2: On a tick where error+6 is below 10, the time grows by exactly 25 and the error grows by exactly 6. Both values are visible one cycle after the tick.
- R3: On a tick where error+6 is 10 or more, the time grows by 26 and the error becomes error+6−10, both on that same tick.
- R4: The correction flag is high for exactly the one cycle that follows a tick that applied the extra LSB, and is low in every other cycle.
- R5: In a cycle without a tick (and without reset), the time and the error keep their values and the flag is low.
- R6: Starting from zero, four back-to-back ticks give time/error of 25/6, 51/2, 76/8 and 102/4. The second and fourth of these ticks are corrected.
- R7: The error accumulator always stays below 10.
- R8: After n ticks from reset (without wrap), time×10 + error equals n×256. For example, 1000 ticks give time 25600 with error 0.
- R9: The time wraps modulo 2^TIME_W. With a 10-bit time, 45 ticks from reset give time 128 with error 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, one tenth of a second elapsed |
| timeVal | output | TIME_W (32) | Elapsed time, unsigned, FRAC_BITS fractional bits |
| errAcc | output | clog2(TICK_DIV) (4) | Remainder accumulator, in tenths of an LSB |
| corrFlag | output | 1 | High one cycle after a tick that added the extra LSB |

## Verification
The base increment and the one-LSB correction land on the same tick. The same is true of the remainder add and the divisor subtract. Long runs of back-to-back ticks provoke these cases, and the scoreboard expects 26 rather than 25 and the wrapped error value there, with the flag raised one cycle later. The bench also raises reset together with a tick, and expects reset to win with all state cleared.

// File: rtl/tenth_time_pkg.sv
package tenth_time_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;    // synchronous clear of all state
    logic advance;  // a tick is being taken this cycle
    logic carry;    // this tick also adds the extra LSB
  } stepCtl_t;

endpackage

// File: rtl/tenth_time_ctrl.sv
module tenth_time_ctrl
  import tenth_time_pkg::*;
#(
  parameter int FRAC_BITS = 8,
  parameter int TICK_DIV  = 10,
  parameter int ERR_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output stepCtl_t         ctl,
  output logic [ERR_W-1:0] errAcc
);

  localparam int ONE_SEC = 1 << FRAC_BITS;
  localparam int REM_INC = ONE_SEC % TICK_DIV;
  localparam logic [ERR_W:0] REM_X = (ERR_W+1)'(REM_INC);
  localparam logic [ERR_W:0] DIV_X = (ERR_W+1)'(TICK_DIV);

  logic [ERR_W:0]   errSum;
  logic             carryNow;
  logic [ERR_W-1:0] errNext;

  generate
    if (REM_INC == 0) begin : g_exact
      // Period is exact in binary: no remainder ever builds up.
      assign errSum   = '0;
      assign carryNow = 1'b0;
      assign errNext  = '0;
    end else begin : g_corrected
      assign errSum   = {1'b0, errAcc} + REM_X;
      assign carryNow = (errSum >= DIV_X);
      always_comb begin
        if (carryNow) errNext = ERR_W'(errSum - DIV_X);
        else          errNext = ERR_W'(errSum);
      end
    end
  endgenerate

  always_comb begin
    ctl.clear   = rst;
    ctl.advance = tick & ~rst;
    ctl.carry   = tick & ~rst & carryNow;
  end

  always_ff @(posedge clk) begin
    if (rst)       errAcc <= '0;
    else if (tick) errAcc <= errNext;
  end

endmodule

// File: rtl/tenth_time_dp.sv
module tenth_time_dp
  import tenth_time_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int FRAC_BITS = 8,
  parameter int TICK_DIV  = 10
) (
  input  logic              clk,
  input  stepCtl_t          ctl,
  output logic [TIME_W-1:0] timeVal,
  output logic              corrFlag
);

  localparam int ONE_SEC  = 1 << FRAC_BITS;
  localparam int BASE_INC = ONE_SEC / TICK_DIV;
  localparam logic [TIME_W-1:0] BASE_T = TIME_W'(BASE_INC);

  logic [TIME_W-1:0] stepAmt;

  always_comb begin
    stepAmt = BASE_T + TIME_W'(ctl.carry);
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      timeVal  <= '0;
      corrFlag <= 1'b0;
    end else begin
      corrFlag <= ctl.carry;
      if (ctl.advance) timeVal <= timeVal + stepAmt;
    end
  end

endmodule

// File: rtl/tenth_time_accum.sv
module tenth_time_accum
  import tenth_time_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int FRAC_BITS = 8,
  parameter int TICK_DIV  = 10,
  localparam int ERR_W    = $clog2(TICK_DIV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [TIME_W-1:0] timeVal,
  output logic [ERR_W-1:0]  errAcc,
  output logic              corrFlag
);

  stepCtl_t ctl;

  tenth_time_ctrl #(
    .FRAC_BITS(FRAC_BITS),
    .TICK_DIV (TICK_DIV),
    .ERR_W    (ERR_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .ctl   (ctl),
    .errAcc(errAcc)
  );

  tenth_time_dp #(
    .TIME_W   (TIME_W),
    .FRAC_BITS(FRAC_BITS),
    .TICK_DIV (TICK_DIV)
  ) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .timeVal (timeVal),
    .corrFlag(corrFlag)
  );

endmodule

// File: rtl/tenth_time_chk.sv
module tenth_time_chk #(
  parameter int TIME_W    = 32,
  parameter int FRAC_BITS = 8,
  parameter int TICK_DIV  = 10,
  parameter int ERR_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [TIME_W-1:0] timeVal,
  input logic [ERR_W-1:0]  errAcc,
  input logic              corrFlag
);

  localparam int ONE_SEC  = 1 << FRAC_BITS;
  localparam int BASE_INC = ONE_SEC / TICK_DIV;
  localparam int REM_INC  = ONE_SEC % TICK_DIV;
  localparam logic [TIME_W-1:0] BASE_T = TIME_W'(BASE_INC);
  localparam logic [TIME_W-1:0] ONE_T  = TIME_W'(1);
  localparam logic [ERR_W-1:0]  REM_E  = ERR_W'(REM_INC);
  localparam logic [ERR_W-1:0]  DIV_E  = ERR_W'(TICK_DIV);
  localparam logic [ERR_W-1:0]  LIM_E  = ERR_W'(TICK_DIV - REM_INC);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (timeVal == '0) && (errAcc == '0) && !corrFlag);

  // R2
  a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
    (tick && (errAcc < LIM_E)) |=>
      (timeVal == $past(timeVal) + BASE_T) && (errAcc == $past(errAcc) + REM_E) && !corrFlag);

  // R3
  a_r3_corrected_step: assert property (@(posedge clk) disable iff (rst)
    (tick && (errAcc >= LIM_E)) |=>
      (timeVal == $past(timeVal) + BASE_T + ONE_T) &&
      (errAcc == $past(errAcc) + REM_E - DIV_E));

  // R4
  a_r4_flag_source: assert property (@(posedge clk) disable iff (rst)
    corrFlag |-> ($past(tick) && ($past(errAcc) >= LIM_E)));

  // R5
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(timeVal) && $stable(errAcc) && !corrFlag);

  // R7
  a_r7_err_bounded: assert property (@(posedge clk) disable iff (rst)
    errAcc < DIV_E);

endmodule

bind tenth_time_accum tenth_time_chk #(
  .TIME_W   (TIME_W),
  .FRAC_BITS(FRAC_BITS),
  .TICK_DIV (TICK_DIV),
  .ERR_W    (ERR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .timeVal (timeVal),
  .errAcc  (errAcc),
  .corrFlag(corrFlag)
);

// File: tb/sim_tenth_time_accum.sv
`timescale 1ns/100ps
module sim_tenth_time_accum;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic tick1 = 1'b0;

  logic [31:0] t0;
  logic [3:0]  e0;
  logic        f0;
  logic [9:0]  t1;
  logic [3:0]  e1;
  logic        f1;

  always #2.5 clk = ~clk;

  tenth_time_accum u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .timeVal(t0), .errAcc(e0), .corrFlag(f0)
  );

  tenth_time_accum #(.TIME_W(10)) u1 (
    .clk(clk), .rst(rst), .tick(tick1),
    .timeVal(t1), .errAcc(e1), .corrFlag(f1)
  );

  typedef struct {
    longint unsigned t;
    int              e;
    bit              f;
    string           tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  longint unsigned mTime = 0;
  int mErr = 0;

  task automatic check(input string tag, input longint unsigned act,
                       input longint unsigned exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: drive one cycle of stimulus, push the expected result.
  task automatic step(input bit r, input bit t, input bit tOther);
    expItem_t it;
    bit c;
    int s;
    @(negedge clk);
    rst = r; tick = t; tick1 = tOther;
    c = 1'b0;
    if (r) begin
      mTime = 0; mErr = 0; it.tag = "R1";
    end else if (t) begin
      s = mErr + 6;
      c = (s >= 10);
      mErr = c ? s - 10 : s;
      mTime = (mTime + 25 + (c ? 1 : 0)) & 64'hFFFF_FFFF;
      it.tag = c ? "R3" : "R2";
    end else begin
      it.tag = "R5";
    end
    it.t = mTime; it.e = mErr; it.f = c;
    expQ.push_back(it);
  endtask

  // Monitor: compare just after each edge.
  initial begin
    forever begin
      expItem_t it;
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.tag, longint'(t0), it.t, "time");
        check(it.tag, longint'(e0), longint'(it.e), "error");
        check("R4", longint'(f0), longint'(it.f), "flag");
        check("R7", longint'(e0 < 4'd10), 1, "error below divisor");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R6 run did not complete: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step(1'b1, 1'b0, 1'b0);

    // R6: first four ticks from zero
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    wait (expQ.size() == 0);
    check("R6", longint'(t0), 102, "time after four ticks");
    check("R6", longint'(e0), 4, "error after four ticks");

    // R5: idle cycles hold
    repeat (3) step(1'b0, 1'b0, 1'b0);

    // R2/R3/R4: sparse and mixed tick patterns
    for (int i = 0; i < 24; i++) step(1'b0, (i % 3) != 1, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, i[0], 1'b0);

    // R1: reset together with a tick
    step(1'b1, 1'b1, 1'b0);

    // R8: long run without drift
    for (int i = 0; i < 1000; i++) step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    wait (expQ.size() == 0);
    check("R8", longint'(t0), 25600, "time after 1000 ticks");
    check("R8", longint'(e0), 0, "error after 1000 ticks");

    // R9: wrap of a narrow time register
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 45; i++) step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    wait (expQ.size() == 0);
    check("R9", longint'(t1), 128, "narrow time after 45 ticks");
    check("R9", longint'(e1), 0, "narrow error after 45 ticks");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule